// File: doc/BRIEF.md
# Address-Mark Wakeup Serial Receiver

This block receives asynchronous serial characters on a multidrop line where every character carries one extra bit above its information bits. When that bit is 1, the character is a node address that opens a new message. Software reads the address character, compares it with its own node address and, if the message belongs to another node, writes 1 to a sleep bit. While asleep the receiver keeps following the line frame by frame, but it raises no receive indication and hands no data to the host.

The next character whose address bit is 1 clears the sleep bit in hardware. The clear happens when that bit is sampled, which is one bit time before the stop bit. The waking character therefore completes like any normal character and becomes the first character the host sees. Idle gaps inside a message do not wake the receiver.

The host uses a small register port. Address 0 returns the received character, and a read strobe on it empties the receive-full indication. Address 1 returns status and control: bit 0 is sleep (read/write), bit 1 is receive-full (read-only) and bit 2 is the address bit of the held character (read-only). The line is sampled on a 16x sample enable that comes from outside the block.

Top module: `amw_rx`

## Requirements
- R1: After reset, the status register (address 1) reads 0x00 and the data register (address 0) reads 0x00.
- R2: With `len_long` = 0 a frame is a start bit (0), seven information bits LSB first, the address bit and a stop bit (1). The character appears in data bits [6:0], data bit 7 reads 0, status bit 1 (full) reads 1 and status bit 2 holds the address bit.
- R3: With `len_long` = 1 the frame carries eight information bits LSB first before the address bit. All eight appear in data bits [7:0].
- R4: A read strobe (`rd_en`) at address 0 clears status bit 1.
- R5: Writing a 1 to status bit 0 sets sleep. While asleep, a character whose address bit is 0 leaves status bit 1 at 0 and leaves the data register unchanged.
- R6: A character whose address bit is 1 clears sleep by itself. That same character is delivered, with full set, its data and status bit 2 = 1.
- R7: While asleep, an idle line of any length and characters with address bit 0 leave sleep set.
- R8: Writing a 0 to status bit 0 clears sleep, and the next frame is delivered normally.
- R9: A low pulse shorter than half a bit time (fewer than 8 sample enables) is discarded as a false start. No character results, and the next proper frame is received.
- R10: While full is set, a newly arrived character is discarded and the held data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | 16x oversampling enable, one clock wide |
| rxd | input | 1 | Serial line, idle high |
| len_long | input | 1 | 0: seven information bits, 1: eight |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (1) | Write address |
| wr_data | input | REG_W (8) | Write data, bit 0 is sleep at address 1 |
| rd_en | input | 1 | Read strobe, clears full at address 0 |
| rd_addr | input | ADDR_W (1) | Read address |
| rd_data | output | REG_W (8) | Read data, combinational on rd_addr |

## Verification
The bench builds the block with its default parameters: eight information bits at most, 16x oversampling and a two-stage line synchronizer. The sample enable arrives every second clock, which keeps a bit time at 32 clocks, so long idle gaps and back-to-back frames stay short. Eight information bits reach both character lengths, including the 7-bit case where the top data bit must read 0. A half-bit of 8 sample enables makes a 3-enable glitch a clear false start.

// File: rtl/amw_pkg.sv
package amw_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
  typedef enum logic [1:0] {SK_INFO, SK_MARK, SK_STOP} samp_kind_t;

  localparam int unsigned REG_DATA   = 0;
  localparam int unsigned REG_CTRL   = 1;
  localparam int unsigned BIT_SLEEP  = 0;
  localparam int unsigned BIT_FULL   = 1;
  localparam int unsigned BIT_MARK   = 2;
endpackage

// File: rtl/amw_sync.sv
module amw_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/amw_framer.sv
module amw_framer
  import amw_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned INFO_W = 8,
  parameter int unsigned IDX_W  = $clog2(INFO_W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx,
  input  logic             len_long,
  output logic             frame_go,
  output logic             samp_stb,
  output samp_kind_t       samp_kind,
  output logic             samp_bit,
  output logic [IDX_W-1:0] samp_idx
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned HALF  = OSR / 2;

  rx_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             prev_q, prev_d;
  logic [IDX_W-1:0] nbits;

  assign nbits = len_long ? IDX_W'(INFO_W) : IDX_W'(INFO_W - 1);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    prev_d   = prev_q;
    samp_stb = 1'b0;
    frame_go = 1'b0;
    if (tick) begin
      prev_d = rx;
      unique case (state_q)
        RX_IDLE: begin
          if (prev_q && !rx) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_W'(HALF - 1)) begin
            if (!rx) begin
              state_d  = RX_BITS;
              cnt_d    = '0;
              idx_d    = '0;
              frame_go = 1'b1;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt_q == CNT_W'(OSR - 1)) begin
            cnt_d    = '0;
            samp_stb = 1'b1;
            idx_d    = idx_q + 1'b1;
            if (idx_q == nbits + 1'b1) state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_comb begin
    if (idx_q < nbits)       samp_kind = SK_INFO;
    else if (idx_q == nbits) samp_kind = SK_MARK;
    else                     samp_kind = SK_STOP;
  end

  assign samp_bit = rx;
  assign samp_idx = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      prev_q  <= prev_d;
    end
  end
endmodule

// File: rtl/amw_capture.sv
module amw_capture
  import amw_pkg::*;
#(
  parameter int unsigned INFO_W = 8,
  parameter int unsigned IDX_W  = $clog2(INFO_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_go,
  input  logic              samp_stb,
  input  samp_kind_t        samp_kind,
  input  logic              samp_bit,
  input  logic [IDX_W-1:0]  samp_idx,
  output logic [INFO_W-1:0] info_q,
  output logic              mark_q
);
  logic [INFO_W-1:0] info_d;
  logic              mark_d;

  always_comb begin
    info_d = info_q;
    mark_d = mark_q;
    if (frame_go) begin
      info_d = '0;
      mark_d = 1'b0;
    end else if (samp_stb) begin
      if (samp_kind == SK_INFO) begin
        for (int i = 0; i < INFO_W; i++) begin
          if (samp_idx == IDX_W'(i)) info_d[i] = samp_bit;
        end
      end else if (samp_kind == SK_MARK) begin
        mark_d = samp_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_q <= '0;
      mark_q <= 1'b0;
    end else begin
      info_q <= info_d;
      mark_q <= mark_d;
    end
  end
endmodule

// File: rtl/amw_hostif.sv
module amw_hostif
  import amw_pkg::*;
#(
  parameter int unsigned INFO_W = 8,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              samp_stb,
  input  samp_kind_t        samp_kind,
  input  logic              samp_bit,
  input  logic [INFO_W-1:0] cap_info,
  input  logic              cap_mark,
  output logic [REG_W-1:0]  rd_data,
  output logic              sleep_q,
  output logic              full_q,
  output logic [INFO_W-1:0] hold_q,
  output logic              hmark_q
);
  logic              sleep_d, full_d, hmark_d;
  logic [INFO_W-1:0] hold_d;
  logic              wake, deliver, rd_clr, ctl_wr;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  always_comb begin
    wake    = samp_stb && (samp_kind == SK_MARK) && samp_bit;
    deliver = samp_stb && (samp_kind == SK_STOP) && !sleep_q && !full_q;
    rd_clr  = rd_en && (rd_addr == ADDR_W'(REG_DATA));
    ctl_wr  = wr_en && (wr_addr == ADDR_W'(REG_CTRL));

    sleep_d = sleep_q;
    if (wake)   sleep_d = 1'b0;
    if (ctl_wr) sleep_d = wr_data[BIT_SLEEP];

    full_d = full_q;
    if (rd_clr)  full_d = 1'b0;
    if (deliver) full_d = 1'b1;

    hold_d  = deliver ? cap_info : hold_q;
    hmark_d = deliver ? cap_mark : hmark_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(REG_DATA)) begin
      rd_data[INFO_W-1:0] = hold_q;
    end else if (rd_addr == ADDR_W'(REG_CTRL)) begin
      rd_data[BIT_SLEEP] = sleep_q;
      rd_data[BIT_FULL]  = full_q;
      rd_data[BIT_MARK]  = hmark_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      full_q  <= 1'b0;
      hold_q  <= '0;
      hmark_q <= 1'b0;
    end else begin
      sleep_q <= sleep_d;
      full_q  <= full_d;
      hold_q  <= hold_d;
      hmark_q <= hmark_d;
    end
  end
endmodule

// File: rtl/amw_rx.sv
module amw_rx
  import amw_pkg::*;
#(
  parameter int unsigned INFO_W      = 8,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REG_W       = 8,
  parameter int unsigned ADDR_W      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rxd,
  input  logic              len_long,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  localparam int unsigned IDX_W = $clog2(INFO_W + 2);

  logic              rst_ns;
  logic              rx_s;
  logic              frame_go;
  logic              samp_stb;
  samp_kind_t        samp_kind;
  logic              samp_bit;
  logic [IDX_W-1:0]  samp_idx;
  logic [INFO_W-1:0] cap_info;
  logic              cap_mark;
  logic              sleep_q, full_q, hmark_q;
  logic [INFO_W-1:0] hold_q;

  amw_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ns)
  );

  amw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_ns), .d(rxd), .q(rx_s)
  );

  amw_framer #(.OSR(OSR), .INFO_W(INFO_W), .IDX_W(IDX_W)) u_framer (
    .clk(clk), .rst_n(rst_ns), .tick(sample_tick), .rx(rx_s),
    .len_long(len_long), .frame_go(frame_go), .samp_stb(samp_stb),
    .samp_kind(samp_kind), .samp_bit(samp_bit), .samp_idx(samp_idx)
  );

  amw_capture #(.INFO_W(INFO_W), .IDX_W(IDX_W)) u_capture (
    .clk(clk), .rst_n(rst_ns), .frame_go(frame_go), .samp_stb(samp_stb),
    .samp_kind(samp_kind), .samp_bit(samp_bit), .samp_idx(samp_idx),
    .info_q(cap_info), .mark_q(cap_mark)
  );

  amw_hostif #(.INFO_W(INFO_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_hostif (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .samp_stb(samp_stb), .samp_kind(samp_kind), .samp_bit(samp_bit),
    .cap_info(cap_info), .cap_mark(cap_mark), .rd_data(rd_data),
    .sleep_q(sleep_q), .full_q(full_q), .hold_q(hold_q), .hmark_q(hmark_q)
  );
endmodule

// File: rtl/amw_rx_chk.sv
module amw_rx_chk
  import amw_pkg::*;
#(
  parameter int unsigned INFO_W = 8,
  parameter int unsigned ADDR_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              samp_stb,
  input samp_kind_t        samp_kind,
  input logic              samp_bit,
  input logic              sleep_q,
  input logic              full_q,
  input logic [INFO_W-1:0] hold_q
);
  logic ctl_wr, data_rd, stop_stb;
  assign ctl_wr   = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
  assign data_rd  = rd_en && (rd_addr == ADDR_W'(REG_DATA));
  assign stop_stb = samp_stb && (samp_kind == SK_STOP);

  AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb |-> tick); // R2

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !stop_stb |=> !full_q); // R4

  AST_NO_FULL_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> !$past(sleep_q)); // R5

  AST_MARK_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb && (samp_kind == SK_MARK) && samp_bit && !ctl_wr |=> !sleep_q); // R6

  AST_SLEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q && !samp_stb && !ctl_wr |=> sleep_q); // R7

  AST_HELD_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(hold_q)); // R10
endmodule

bind amw_rx amw_rx_chk #(.INFO_W(INFO_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_ns), .tick(sample_tick), .wr_en(wr_en),
  .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
  .samp_stb(samp_stb), .samp_kind(samp_kind), .samp_bit(samp_bit),
  .sleep_q(sleep_q), .full_q(full_q), .hold_q(hold_q)
);

// File: tb/tb_amw_rx.sv
module tb_amw_rx;
  localparam int TDIV    = 2;
  localparam int OSR     = 16;
  localparam int BIT_CLK = TDIV * OSR;

  // vector: [22:21] ctl (0 none,1 sleep,2 wake) [20] long [19] mark [18:11] info
  //         [10] exp full [9] exp sleep [8] exp mark [7:0] exp data
  localparam logic [22:0] VEC [0:7] = '{
    {2'd0, 1'b0, 1'b0, 8'h35, 1'b1, 1'b0, 1'b0, 8'h35},
    {2'd0, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b1, 8'hA5},
    {2'd1, 1'b0, 1'b0, 8'h12, 1'b0, 1'b1, 1'b1, 8'hA5},
    {2'd1, 1'b0, 1'b1, 8'h4F, 1'b1, 1'b0, 1'b1, 8'h4F},
    {2'd1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b1, 8'h4F},
    {2'd2, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 1'b0, 8'h3C},
    {2'd0, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h7F},
    {2'd1, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0, 1'b1, 8'h81}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick;
  logic       rxd = 1'b1;
  logic       len_long = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [0:0] rd_addr = 1'b0;
  logic [7:0] rd_data;
  int         tcnt = 0;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
  assign sample_tick = (tcnt == 0);

  amw_rx dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .len_long(len_long), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic lng, input logic [7:0] info, input logic mk);
    @(negedge clk);
    len_long = lng;
    rxd = 1'b0;
    wait_bits(1);
    for (int i = 0; i < (lng ? 8 : 7); i++) begin
      rxd = info[i];
      wait_bits(1);
    end
    rxd = mk;
    wait_bits(1);
    rxd = 1'b1;
    wait_bits(2);
  endtask

  task automatic rd_peek(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic rd_take(output logic [7:0] v);
    @(negedge clk);
    rd_addr = 1'b0;
    rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_ctl(input logic s);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 1'b1;
    wr_data = {7'd0, s};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    rd_peek(1'b1, v); chk("R1 status after reset", v, 8'h00);
    rd_peek(1'b0, v); chk("R1 data after reset", v, 8'h00);

    // table: R2/R3 formats, R5 sleep, R6 wake, R8 software clear
    for (int k = 0; k < 8; k++) begin
      logic [22:0] e;
      e = VEC[k];
      if (e[22:21] == 2'd1) wr_ctl(1'b1);
      else if (e[22:21] == 2'd2) wr_ctl(1'b0);
      send(e[20], e[18:11], e[19]);
      rd_peek(1'b1, v);
      chk($sformatf("R2 R3 R5 R6 R8 vec%0d status", k), v,
          {5'd0, e[8], e[10], e[9]});
      rd_take(v);
      chk($sformatf("R2 R3 R5 R6 vec%0d data", k), v, e[7:0]);
      rd_peek(1'b1, v);
      chk($sformatf("R4 vec%0d full cleared", k), v & 8'h02, 8'h00);
    end

    // R10: second character while full is dropped
    send(1'b1, 8'h11, 1'b0);
    send(1'b1, 8'h22, 1'b0);
    rd_peek(1'b1, v); chk("R10 status full", v, 8'h02);
    rd_take(v);       chk("R10 older data kept", v, 8'h11);
    rd_peek(1'b1, v); chk("R4 full cleared after read", v, 8'h00);

    // R9: short low glitch is a false start
    @(negedge clk);
    rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1;
    wait_bits(2);
    rd_peek(1'b1, v); chk("R9 no character from glitch", v, 8'h00);
    send(1'b1, 8'h5A, 1'b0);
    rd_take(v);       chk("R9 next frame received", v, 8'h5A);

    // R7: long idle and a non-address character keep sleep
    wr_ctl(1'b1);
    wait_bits(40);
    rd_peek(1'b1, v); chk("R7 sleep kept over idle", v, 8'h01);
    send(1'b0, 8'h33, 1'b0);
    rd_peek(1'b1, v); chk("R7 sleep kept on data char", v, 8'h01);
    rd_peek(1'b0, v); chk("R5 data untouched while asleep", v, 8'h5A);
    wr_ctl(1'b0);
    rd_peek(1'b1, v); chk("R8 sleep cleared by write", v, 8'h00);

    finish_run();
  end
endmodule